// File: doc/BRIEF.md
# Remote DMA Host Data Port

This block gives a host processor access to a network controller's local packet buffer through a single data port. Software first loads a 16-bit buffer address and a 16-bit remaining byte count, one byte at a time. It then issues a remote read or remote write command and moves data through the port with read or write strobes. Every access moves 1, 2 or 4 bytes. After each access the address steps forward and the count steps down. When the address reaches the end of the receive ring it folds back to the ring's first page.

The buffer memory sits outside the block as four byte-wide banks. Each bank takes its own row address, so an access of any width at any byte offset completes in one clock. Read data comes back on the next cycle. Only two address windows hold real storage. Bytes outside them are never written and read back as all ones. A sticky completion flag marks the end of a transfer. It also marks a remote command issued with nothing left to move. A write-one pulse from the interrupt logic clears it.

Top module: `rdma_data_port`

## Requirements
- R1: The address and count registers are 16 bits wide and reset to 0. Each is loaded with separate low-byte and high-byte strobes from `reg_wdata`. A load in the same cycle as a port access takes precedence over the access's update of that register.
- R2: The access size is 4 bytes when `port_dw` is 1, otherwise 2 bytes when `wide_mode` is 1, otherwise 1 byte. Each performed access adds the size to the stored address, modulo 2^16.
- R3: When the advanced address equals `stop_page` × 256, the address is loaded with `start_page` × 256 instead.
- R4: On each performed access, a remaining count less than or equal to the access size becomes 0 and sets `done`. Otherwise the count drops by the access size.
- R5: While the count is 0, a port write writes no memory and leaves the address and the count unchanged. Port reads are still performed.
- R6: A byte address is valid when it is below 32, or when it is at least 16384 and below 49152. Invalid bytes are never written and read as 0xFF. Port read bytes above the access size read as 0x00.
- R7: Two-byte and four-byte accesses clear bit 0 of the address used for memory, not of the stored address. Port byte i (bits 8i+7..8i) maps to buffer byte address base+i, which is little-endian order.
- R8: `port_rdata` and `rd_valid` = 1 appear on the cycle after a `port_rd` strobe.
- R9: A `cmd_we` pulse with `cmd_rd` or `cmd_wr` set while the count is 0 sets `done`.
- R10: `done` stays 1 until a `done_clr` pulse. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wdata | input | 8 | Byte written by the register load strobes |
| addr_lo_we | input | 1 | Load address bits 7..0 |
| addr_hi_we | input | 1 | Load address bits 15..8 |
| cnt_lo_we | input | 1 | Load count bits 7..0 |
| cnt_hi_we | input | 1 | Load count bits 15..8 |
| start_page | input | 8 | First page of the ring |
| stop_page | input | 8 | Page just past the end of the ring |
| cmd_we | input | 1 | Command write strobe |
| cmd_rd | input | 1 | Remote read command bit |
| cmd_wr | input | 1 | Remote write command bit |
| wide_mode | input | 1 | Two-byte port accesses |
| port_dw | input | 1 | Four-byte port access |
| port_rd | input | 1 | Data port read strobe |
| port_wr | input | 1 | Data port write strobe |
| port_wdata | input | 32 | Data port write data |
| port_rdata | output | 32 | Data port read data |
| rd_valid | output | 1 | Read data valid |
| mem_we | output | 1 | Memory write (else read) for enabled banks |
| mem_be | output | 4 | Per-bank enable |
| mem_row | output | 56 | Per-bank row address, 14 bits per bank |
| mem_wdata | output | 32 | Per-bank write byte |
| mem_rdata | input | 32 | Per-bank read byte, one cycle after enable |
| done_clr | input | 1 | Clear pulse for the completion flag |
| done | output | 1 | Remote transfer complete flag |
| cur_addr | output | 16 | Current buffer address |
| cur_cnt | output | 16 | Remaining byte count |

## Verification
The bench targets the places where this block is easiest to get wrong.

- **Ring wrap.** Byte writes run across the stop page. A design that compared against the wrong bound would run past the ring end instead of folding back.
- **Count underflow.** A count smaller than a four-byte access must stop at zero. A design that got this wrong would underflow to a large count and never flag completion.
- **Window edges.** Accesses straddle the 32, 16384, 49152 and 65535 boundaries. These expose bytes that are wrongly written or that return stored data where 0xFF is due.
- **Odd addresses and byte order.** Word accesses at odd addresses, and byte reads of a four-byte write, catch a missing even-address force and reversed lane order.
- **Zero-count cases.** Writes at count zero and zero-length commands catch a design that changes state with no bytes left, or that fails to raise `done` at once.

// File: rtl/rdma_data_port.sv
module rdma_data_port #(
  parameter int AW        = 16,
  parameter int PW        = 8,
  parameter int LOW_LIMIT = 32,
  parameter int WIN_BASE  = 16384,
  parameter int WIN_END   = 49152,
  localparam int NB       = 4,
  localparam int RW       = AW - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_wdata,
  input  logic             addr_lo_we,
  input  logic             addr_hi_we,
  input  logic             cnt_lo_we,
  input  logic             cnt_hi_we,
  input  logic [PW-1:0]    start_page,
  input  logic [PW-1:0]    stop_page,
  input  logic             cmd_we,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             wide_mode,
  input  logic             port_dw,
  input  logic             port_rd,
  input  logic             port_wr,
  input  logic [8*NB-1:0]  port_wdata,
  output logic [8*NB-1:0]  port_rdata,
  output logic             rd_valid,
  output logic             mem_we,
  output logic [NB-1:0]    mem_be,
  output logic [NB*RW-1:0] mem_row,
  output logic [8*NB-1:0]  mem_wdata,
  input  logic [8*NB-1:0]  mem_rdata,
  input  logic             done_clr,
  output logic             done,
  output logic [AW-1:0]    cur_addr,
  output logic [AW-1:0]    cur_cnt
);
  localparam int SH = AW - PW;

  function automatic logic in_win(input logic [AW-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    return (w < 32'(LOW_LIMIT)) || (w >= 32'(WIN_BASE) && w < 32'(WIN_END));
  endfunction

  logic [AW-1:0] addr_q, cnt_q, base, adv, nxt;
  logic [2:0]    sz, sz_q;
  logic [1:0]    lo_q;
  logic [NB-1:0] ok_now, ok_q;
  logic          done_q, rdv_q;
  logic          go_rd, go_wr, step, aload, cload, fin, set_done;

  assign sz    = port_dw ? 3'd4 : (wide_mode ? 3'd2 : 3'd1);
  assign base  = (port_dw || wide_mode) ? {addr_q[AW-1:1], 1'b0} : addr_q;
  assign go_rd = port_rd;
  assign go_wr = port_wr && !port_rd && (cnt_q != '0);
  assign step  = go_rd || go_wr;
  assign aload = addr_lo_we || addr_hi_we;
  assign cload = cnt_lo_we || cnt_hi_we;
  assign adv   = addr_q + AW'(sz);
  assign nxt   = (adv == {stop_page, {SH{1'b0}}}) ? {start_page, {SH{1'b0}}} : adv;
  assign fin   = cnt_q <= AW'(sz);
  assign set_done = (step && !cload && fin) ||
                    (cmd_we && (cmd_rd || cmd_wr) && cnt_q == '0);
  assign mem_we = go_wr;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    logic [1:0]    lane;
    logic [AW-1:0] ba;
    assign lane = 2'(k) - base[1:0];
    assign ba   = base + AW'(lane);
    assign mem_be[k] = step && ({1'b0, lane} < sz) && in_win(ba);
    assign mem_row[k*RW +: RW] = ba[AW-1:2];
    assign mem_wdata[8*k +: 8] = port_wdata[{lane, 3'b000} +: 8];
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [1:0] bank;
    assign ok_now[i] = in_win(base + AW'(i));
    assign bank = lo_q + 2'(i);
    assign port_rdata[8*i +: 8] = (3'(i) >= sz_q) ? 8'h00 :
                                  (ok_q[i] ? mem_rdata[{bank, 3'b000} +: 8] : 8'hFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      sz_q   <= 3'd1;
      lo_q   <= '0;
      ok_q   <= '0;
    end else begin
      if (aload) begin
        if (addr_lo_we) addr_q[7:0]    <= reg_wdata;
        if (addr_hi_we) addr_q[AW-1:8] <= reg_wdata[AW-9:0];
      end else if (step) begin
        addr_q <= nxt;
      end
      if (cload) begin
        if (cnt_lo_we) cnt_q[7:0]    <= reg_wdata;
        if (cnt_hi_we) cnt_q[AW-1:8] <= reg_wdata[AW-9:0];
      end else if (step) begin
        cnt_q <= fin ? '0 : cnt_q - AW'(sz);
      end
      if (set_done)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
      rdv_q <= go_rd;
      if (go_rd) begin
        sz_q <= sz;
        lo_q <= base[1:0];
        ok_q <= ok_now;
      end
    end
  end

  assign rd_valid = rdv_q;
  assign done     = done_q;
  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;

  AST_RDVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> rd_valid); // R8
  AST_WR_HELD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && cur_cnt == '0 && !aload && !cload) |=> ($stable(cur_addr) && cur_cnt == '0)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done); // R10
  AST_CNT_EXHAUST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_cnt) != '0 && cur_cnt == '0 && !$past(cload)) |-> done); // R4
  AST_PAD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && sz_q == 3'd1) |-> port_rdata[8*NB-1:8] == '0); // R6
endmodule

// File: tb/tb_rdma_data_port.sv
`timescale 1ns/1ps
module tb_rdma_data_port;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_wdata = 0;
  logic addr_lo_we = 0, addr_hi_we = 0, cnt_lo_we = 0, cnt_hi_we = 0;
  logic [7:0] start_page = 8'h40, stop_page = 8'h80;
  logic cmd_we = 0, cmd_rd = 0, cmd_wr = 0;
  logic wide_mode = 0, port_dw = 0, port_rd = 0, port_wr = 0;
  logic [31:0] port_wdata = 0, port_rdata, mem_wdata, mem_rdata;
  logic rd_valid, mem_we, done_clr = 0, done;
  logic [3:0] mem_be;
  logic [55:0] mem_row;
  logic [15:0] cur_addr, cur_cnt;

  always #2 clk = ~clk;

  rdma_data_port dut (.*);

  logic [7:0] bmem [0:3][0:16383];
  logic [7:0] ref_mem [0:65535];
  logic [31:0] brd = 0;
  assign mem_rdata = brd;

  always @(posedge clk)
    for (int k = 0; k < 4; k++)
      if (mem_be[k]) begin
        if (mem_we) bmem[k][mem_row[k*14 +: 14]] <= mem_wdata[8*k +: 8];
        else        brd[8*k +: 8] <= bmem[k][mem_row[k*14 +: 14]];
      end

  int checks = 0, errors = 0;
  logic [15:0] m_addr = 0, m_cnt = 0;
  bit m_done = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7) ^ (a >> 8) ^ 8'h5A);
  endfunction

  function automatic bit win(input logic [15:0] a);
    return (a < 16'd32) || (a >= 16'd16384 && a < 16'd49152);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string tag);
    chk(cur_addr === m_addr, tag, 32'(cur_addr), 32'(m_addr));
    chk(cur_cnt === m_cnt, "R4 count", 32'(cur_cnt), 32'(m_cnt));
    chk(done === m_done, "R10 done flag", 32'(done), 32'(m_done));
  endtask

  task automatic load_addr(input logic [15:0] a);
    @(negedge clk); addr_lo_we = 1; reg_wdata = a[7:0];
    @(negedge clk); addr_lo_we = 0; addr_hi_we = 1; reg_wdata = a[15:8];
    @(negedge clk); addr_hi_we = 0;
    m_addr = a;
  endtask

  task automatic load_cnt(input logic [15:0] c);
    @(negedge clk); cnt_lo_we = 1; reg_wdata = c[7:0];
    @(negedge clk); cnt_lo_we = 0; cnt_hi_we = 1; reg_wdata = c[15:8];
    @(negedge clk); cnt_hi_we = 0;
    m_cnt = c;
  endtask

  task automatic issue_cmd(input bit rd, input bit wr);
    @(negedge clk); cmd_we = 1; cmd_rd = rd; cmd_wr = wr;
    @(negedge clk); cmd_we = 0; cmd_rd = 0; cmd_wr = 0;
    if (m_cnt == 0 && (rd || wr)) m_done = 1;
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
    m_done = 0;
  endtask

  task automatic do_access(input bit rd, input bit dw, input bit wm,
                           input logic [31:0] wd, input string tag);
    logic [2:0] sz;
    logic [15:0] base, a, adv;
    logic [31:0] exp;
    sz = dw ? 3'd4 : (wm ? 3'd2 : 3'd1);
    base = (dw || wm) ? {m_addr[15:1], 1'b0} : m_addr;
    exp = 0;
    for (int i = 0; i < 4; i++) begin
      a = base + 16'(i);
      if (i < int'(sz)) begin
        if (rd) exp[8*i +: 8] = win(a) ? ref_mem[a] : 8'hFF;
        else if (m_cnt != 0 && win(a)) ref_mem[a] = wd[8*i +: 8];
      end
    end
    if (rd || m_cnt != 0) begin
      adv = m_addr + 16'(sz);
      m_addr = (adv == {stop_page, 8'h00}) ? {start_page, 8'h00} : adv;
      if (m_cnt <= 16'(sz)) begin m_cnt = 0; m_done = 1; end
      else m_cnt = m_cnt - 16'(sz);
    end
    @(negedge clk); port_rd = rd; port_wr = !rd; port_dw = dw; wide_mode = wm; port_wdata = wd;
    @(negedge clk); port_rd = 0; port_wr = 0;
    if (rd) begin
      chk(rd_valid === 1'b1, "R8 read valid", 32'(rd_valid), 32'd1);
      chk(port_rdata === exp, tag, port_rdata, exp);
    end
    check_state(tag);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 6)
      0: return 16'($urandom % 64);
      1: return 16'(16384 - 8 + $urandom % 16);
      2: return 16'(49152 - 8 + $urandom % 16);
      3: return {stop_page, 8'h00} - 16'(8) + 16'($urandom % 8);
      4: return 16'(65532 + $urandom % 4);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 65536; a++) begin
      bmem[a % 4][a / 4] = pat(a);
      ref_mem[a] = pat(a);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset address");
    chk(rd_valid === 1'b0, "R1 reset valid", 32'(rd_valid), 0);

    load_addr(16'h4010); load_cnt(16'h0105);
    check_state("R1 byte loads");

    load_cnt(16'h0000);
    do_access(0, 0, 0, 32'h000000EE, "R5 write at zero count");
    do_access(1, 0, 0, 0, "R5 location untouched");
    clear_done();
    check_state("R10 clear");

    issue_cmd(0, 1);
    check_state("R9 zero-length write command");
    @(negedge clk);
    check_state("R10 held");
    clear_done();
    issue_cmd(1, 0);
    check_state("R9 zero-length read command");
    clear_done();

    start_page = 8'h40; stop_page = 8'h80;
    load_addr(16'h7FFE); load_cnt(16'd3);
    do_access(0, 0, 0, 32'h11, "R2 byte step");
    do_access(0, 0, 0, 32'h22, "R3 wrap to start");
    do_access(0, 0, 0, 32'h33, "R4 last byte sets done");
    clear_done();

    load_addr(16'h4101); load_cnt(16'd8);
    do_access(1, 0, 1, 0, "R7 odd word address");
    load_addr(16'h4200); load_cnt(16'd8);
    do_access(0, 1, 0, 32'hA1B2C3D4, "R7 dword write");
    load_addr(16'h4200);
    do_access(1, 0, 0, 0, "R7 little-endian byte 0");
    do_access(1, 0, 0, 0, "R7 little-endian byte 1");

    load_addr(16'h0100); load_cnt(16'd20);
    do_access(1, 1, 0, 0, "R6 invalid dword read");
    load_addr(16'h001E);
    do_access(1, 1, 0, 0, "R6 straddling low window");
    load_addr(16'hC000);
    do_access(1, 0, 1, 0, "R6 invalid word read");
    load_addr(16'h001E);
    do_access(0, 1, 0, 32'h99887766, "R6 straddling write");
    chk(bmem[0][8] === pat(32), "R6 invalid byte not written", 32'(bmem[0][8]), 32'(pat(32)));
    load_addr(16'hFFFE);
    do_access(1, 1, 0, 0, "R6 top wrap read");
    load_cnt(16'd3);
    do_access(1, 1, 0, 0, "R4 count below size");
    clear_done();

    for (int n = 0; n < 1500; n++) begin
      if (n % 300 == 0) begin
        @(negedge clk);
        start_page = 8'h40 + 8'($urandom % 32);
        stop_page  = 8'h60 + 8'($urandom % 96);
      end
      case ($urandom % 16)
        0, 1: load_addr(pick_addr());
        2:    load_cnt(16'($urandom % 40));
        3:    issue_cmd(1'($urandom), 1'($urandom));
        4:    clear_done();
        default: do_access(1'($urandom), ($urandom % 3) == 0, 1'($urandom), $urandom, "R2 random access");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule